// File: doc/BRIEF.md
# Dual Reference Selector with Holdover

This block watches two reference clock inputs, A and B, that arrive unrelated to the system clock. It samples each one into the system-clock domain and divides it by its own programmable integer. It then forwards one divided reference to a downstream phase detector. The forwarded signal is a one-cycle strobe for every divided rising edge.

Each input has a loss monitor. Selection is automatic, taken from a select pin, or forced to one input, as a 3-bit mode field chooses. In automatic mode the block moves to the surviving input when the active one fails. When both inputs are lost the block enters holdover. It then tells the charge-pump interface either to tristate or to park at midscale, as a register bit chooses. It leaves holdover as soon as one reference is counted present again. Holdover and the applied selection are reported as status bits.

A change of selection waits for the first divided edge of the newly chosen input. Stale edges of the old input are never forwarded.

Top module: `refsel_top`

## Requirements
- R1: With divider value N, consecutive `ref_out` strobes of the selected input are N reference periods apart. N ranges up to 1023, and values 0 and 1 both divide by one.
- R2: Input B uses `div_a_val` as its divider while `div_b_indep` is 0, and uses `div_b_val` while it is 1.
- R3: An input is marked lost once more than `loss_limit` system-clock cycles pass without a rising edge. A lost input counts as present again after 4 consecutive edges that are each within that limit.
- R4: In automatic mode, when the active input is lost and the other is present, the block switches to the other input without entering holdover.
- R5: While both inputs are lost, `stat_holdover` is 1 and `ref_out` stays 0.
- R6: `cp_mode` is 0 (drive) outside holdover. In holdover it is 1 (tristate) when `hold_mid_en` is 0 and 2 (midscale) when it is 1.
- R7: Holdover ends once an input is present again. That input is then selected and `cp_mode` returns to 0.
- R8: `sel_mode` encoding: 1 follows `sel_pin` (0 = A, 1 = B), 2 forces A, 3 forces B. Values 0 and 4 to 7 select automatically, without reverting to A.
- R9: `stat_sel_b` shows the applied input (0 = A, 1 = B) in automatic mode and reads 0 in any other mode.
- R10: A selection change takes effect on the first divided strobe of the newly chosen input. No strobe of the old input is forwarded once the change is requested.
- R11: After reset, `ref_out` is 0, `stat_holdover` is 1, `cp_mode` is 1 and `stat_sel_b` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a | input | 1 | Reference clock A (asynchronous) |
| ref_b | input | 1 | Reference clock B (asynchronous) |
| div_a_val | input | DIV_W | Divider value for A (and for B when shared) |
| div_b_val | input | DIV_W | Divider value for B when independent |
| div_b_indep | input | 1 | 1: B uses its own divider value |
| sel_mode | input | 3 | Selection mode field |
| sel_pin | input | 1 | Manual select pin (0 = A, 1 = B) |
| hold_mid_en | input | 1 | 1: park charge pump at midscale in holdover |
| loss_limit | input | LIM_W | Loss timeout in system-clock cycles |
| ref_out | output | 1 | Divided strobe of the selected reference |
| cp_mode | output | 2 | Charge-pump mode: 0 drive, 1 tristate, 2 midscale |
| stat_holdover | output | 1 | Holdover active |
| stat_sel_b | output | 1 | Applied reference in automatic mode |

## Verification
The bench builds the block with its default parameters: 10-bit dividers, a 16-bit loss timeout and a recovery count of four edges. The 10-bit divider puts the divide-by-1023 corner within reach alongside the 0 and 1 aliases. The 16-bit timeout lets loss limits straddle the reference period, so both a false loss and a real loss can be provoked. The four-edge recovery count is small enough to test holdover exit on either side of the edge threshold, using reference periods of only a few system-clock cycles.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    CP_DRIVE    = 2'd0,
    CP_TRISTATE = 2'd1,
    CP_MIDSCALE = 2'd2
  } cp_mode_e;

  localparam logic [2:0] MODE_AUTO    = 3'd0;
  localparam logic [2:0] MODE_PIN     = 3'd1;
  localparam logic [2:0] MODE_FORCE_A = 3'd2;
  localparam logic [2:0] MODE_FORCE_B = 3'd3;

  function automatic logic mode_is_auto(input logic [2:0] m);
    return !(m == MODE_PIN || m == MODE_FORCE_A || m == MODE_FORCE_B);
  endfunction

endpackage

// File: rtl/refsel_div.sv
// Brings one reference into the system-clock domain, finds its rising
// edges and divides them down to a one-cycle strobe.
module refsel_div #(
  parameter int DIV_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic [DIV_W-1:0] div_val,
  output logic             edge_o,
  output logic             strobe_o
);
  localparam int SH_W = SYNC_N + 1;

  logic [SH_W-1:0]  sh_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SH_W-2:0], ref_in};
  end

  assign edge_o   = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  // 0 and 1 both give divide-by-one
  assign last_idx = (div_val == '0) ? '0 : div_val - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (edge_o) begin
        if (cnt_q >= last_idx) begin
          cnt_q    <= '0;
          strobe_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_strobe_from_edge_R1: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $past(edge_o));
  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);

endmodule

// File: rtl/refsel_mon.sv
// Loss monitor: times the gap between edges and needs a run of good edges
// before a lost input counts as present again.
module refsel_mon #(
  parameter int LIM_W      = 16,
  parameter int GOOD_EDGES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic [LIM_W-1:0] limit,
  output logic             missing_o
);
  localparam int GC_W = $clog2(GOOD_EDGES + 1);
  localparam logic [GC_W-1:0] GOOD_LAST = GC_W'(GOOD_EDGES - 1);

  logic [LIM_W-1:0] gap_q;
  logic [GC_W-1:0]  good_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q     <= '0;
      good_q    <= '0;
      missing_o <= 1'b1;
    end else if (edge_i) begin
      gap_q <= '0;
      if (missing_o) begin
        if (good_q >= GOOD_LAST) begin
          missing_o <= 1'b0;
          good_q    <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end else if (gap_q >= limit) begin
      missing_o <= 1'b1;
      good_q    <= '0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_no_loss_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> !$rose(missing_o));
  assert_recover_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(missing_o) |-> $past(edge_i));

endmodule

// File: rtl/refsel_ctrl.sv
// Selection, holdover and charge-pump control.
module refsel_ctrl
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] miss,
  input  logic [1:0] strobe,
  input  logic [2:0] sel_mode,
  input  logic       sel_pin,
  input  logic       hold_mid_en,
  output logic       ref_out,
  output logic [1:0] cp_mode,
  output logic       stat_holdover,
  output logic       stat_sel_b
);
  logic want_q, want_n;
  logic cur_q, cur_n;
  logic hold_n;

  always_comb begin
    case (sel_mode)
      MODE_PIN:     want_n = sel_pin;
      MODE_FORCE_A: want_n = 1'b0;
      MODE_FORCE_B: want_n = 1'b1;
      default:      want_n = (miss[want_q] && !miss[~want_q]) ? ~want_q : want_q;
    endcase
  end

  assign hold_n = miss[0] & miss[1];
  // the applied choice follows the target only on the target's own strobe
  assign cur_n  = strobe[want_q] ? want_q : cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      want_q        <= 1'b0;
      cur_q         <= 1'b0;
      ref_out       <= 1'b0;
      stat_holdover <= 1'b1;
      cp_mode       <= CP_TRISTATE;
      stat_sel_b    <= 1'b0;
    end else begin
      want_q        <= want_n;
      cur_q         <= cur_n;
      ref_out       <= strobe[want_q] & ~hold_n;
      stat_holdover <= hold_n;
      if (!hold_n)         cp_mode <= CP_DRIVE;
      else if (hold_mid_en) cp_mode <= CP_MIDSCALE;
      else                 cp_mode <= CP_TRISTATE;
      stat_sel_b    <= mode_is_auto(sel_mode) ? cur_n : 1'b0;
    end
  end

  assert_quiet_in_holdover_R5: assert property (@(posedge clk) disable iff (rst)
    ref_out |-> !stat_holdover);
  assert_cp_parked_R6: assert property (@(posedge clk) disable iff (rst)
    stat_holdover |-> (cp_mode != CP_DRIVE));
  assert_cp_driving_R7: assert property (@(posedge clk) disable iff (rst)
    !stat_holdover |-> (cp_mode == CP_DRIVE));
  assert_manual_status_R9: assert property (@(posedge clk) disable iff (rst)
    !mode_is_auto(sel_mode) |=> !stat_sel_b);
  assert_switch_on_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (cur_q != $past(cur_q)) |-> $past(strobe[want_q]));

endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
  parameter int DIV_W      = 10,
  parameter int LIM_W      = 16,
  parameter int GOOD_EDGES = 4,
  parameter int SYNC_N     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_a,
  input  logic             ref_b,
  input  logic [DIV_W-1:0] div_a_val,
  input  logic [DIV_W-1:0] div_b_val,
  input  logic             div_b_indep,
  input  logic [2:0]       sel_mode,
  input  logic             sel_pin,
  input  logic             hold_mid_en,
  input  logic [LIM_W-1:0] loss_limit,
  output logic             ref_out,
  output logic [1:0]       cp_mode,
  output logic             stat_holdover,
  output logic             stat_sel_b
);
  localparam int NREF = 2;

  logic [NREF-1:0]  ref_w;
  logic [NREF-1:0]  edge_w;
  logic [NREF-1:0]  strobe_w;
  logic [NREF-1:0]  miss_w;
  logic [DIV_W-1:0] div_cfg [NREF];

  assign ref_w      = {ref_b, ref_a};
  assign div_cfg[0] = div_a_val;
  assign div_cfg[1] = div_b_indep ? div_b_val : div_a_val;

  for (genvar i = 0; i < NREF; i++) begin : g_ch
    refsel_div #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_div (
      .clk(clk), .rst(rst), .ref_in(ref_w[i]), .div_val(div_cfg[i]),
      .edge_o(edge_w[i]), .strobe_o(strobe_w[i]));
    refsel_mon #(.LIM_W(LIM_W), .GOOD_EDGES(GOOD_EDGES)) u_mon (
      .clk(clk), .rst(rst), .edge_i(edge_w[i]), .limit(loss_limit),
      .missing_o(miss_w[i]));
  end

  refsel_ctrl u_ctrl (
    .clk(clk), .rst(rst), .miss(miss_w), .strobe(strobe_w),
    .sel_mode(sel_mode), .sel_pin(sel_pin), .hold_mid_en(hold_mid_en),
    .ref_out(ref_out), .cp_mode(cp_mode), .stat_holdover(stat_holdover),
    .stat_sel_b(stat_sel_b));

endmodule

// File: tb/tb_refsel_top.sv
module tb_refsel_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_a = 1'b0, ref_b = 1'b0;
  logic [9:0] div_a_val = 10'd1, div_b_val = 10'd1;
  logic div_b_indep = 1'b0;
  logic [2:0] sel_mode = 3'd2;
  logic sel_pin = 1'b0, hold_mid_en = 1'b0;
  logic [15:0] loss_limit = 16'd200;
  logic ref_out, stat_holdover, stat_sel_b;
  logic [1:0] cp_mode;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, pulse_cnt = 0, last_t = 0;
  bit en_a = 0, en_b = 0, seen_hold = 0, done = 0;
  int half_a = 3, half_b = 4, ca = 0, cb = 0;

  refsel_top dut (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!en_a) begin ref_a <= 1'b0; ca <= 0; end
    else if (ca >= half_a - 1) begin ref_a <= ~ref_a; ca <= 0; end
    else ca <= ca + 1;
    if (!en_b) begin ref_b <= 1'b0; cb <= 0; end
    else if (cb >= half_b - 1) begin ref_b <= ~ref_b; cb <= 0; end
    else cb <= cb + 1;
    if (ref_out) begin pulse_cnt <= pulse_cnt + 1; last_t <= cyc; end
    if (stat_holdover) seen_hold <= 1'b1;
  end

  function automatic int exp_spacing(input int n, input int half);
    return ((n < 2) ? 1 : n) * 2 * half;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic next_pulse(output int t);
    int c0 = pulse_cnt;
    t = -1;
    for (int k = 0; k < 9000; k++) begin
      @(negedge clk);
      if (pulse_cnt != c0) begin t = last_t; return; end
    end
  endtask

  task automatic measure(input int skip, output int sp);
    int t1, t2;
    for (int k = 0; k < skip; k++) next_pulse(t1);
    next_pulse(t1);
    next_pulse(t2);
    sp = (t1 < 0 || t2 < 0) ? -1 : t2 - t1;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int sp, n, h, c0;
    void'($urandom(32'd20240611));
    cycles(5);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(ref_out == 1'b0, "R11 ref_out", ref_out, 0);
    check(stat_holdover == 1'b1, "R11 holdover", stat_holdover, 1);
    check(cp_mode == 2'd1, "R11 cp_mode", cp_mode, 1);
    check(stat_sel_b == 1'b0, "R11 sel", stat_sel_b, 0);

    en_a = 1; en_b = 1;
    cycles(100);
    // R1 directed corners
    half_a = 3; div_a_val = 10'd0; measure(2, sp);
    check(sp == exp_spacing(0, 3), "R1 div0", sp, exp_spacing(0, 3));
    div_a_val = 10'd1; measure(2, sp);
    check(sp == exp_spacing(1, 3), "R1 div1", sp, exp_spacing(1, 3));
    half_a = 2; div_a_val = 10'd1023; measure(1, sp);
    check(sp == exp_spacing(1023, 2), "R1 div1023", sp, exp_spacing(1023, 2));
    // R1 random
    for (int i = 0; i < 6; i++) begin
      n = $urandom_range(0, 12); h = $urandom_range(2, 6);
      half_a = h; div_a_val = 10'(n);
      measure(2, sp);
      check(sp == exp_spacing(n, h), "R1 random", sp, exp_spacing(n, h));
    end
    // R2 shared / independent B divider
    sel_mode = 3'd3; half_b = 4; div_a_val = 10'd3; div_b_indep = 0;
    measure(2, sp);
    check(sp == exp_spacing(3, 4), "R2 shared", sp, exp_spacing(3, 4));
    div_b_indep = 1; div_b_val = 10'd7;
    measure(2, sp);
    check(sp == exp_spacing(7, 4), "R2 indep", sp, exp_spacing(7, 4));

    // R3 / R4 loss and automatic switch
    div_a_val = 10'd2; div_b_val = 10'd3; half_a = 3;
    sel_mode = 3'd2; cycles(100);
    sel_mode = 3'd0; half_a = 25; loss_limit = 16'd60;
    cycles(400);
    check(stat_sel_b == 1'b0, "R3 no false loss", stat_sel_b, 0);
    seen_hold = 0;
    loss_limit = 16'd40;
    cycles(300);
    check(stat_sel_b == 1'b1, "R4 switched to B", stat_sel_b, 1);
    check(seen_hold == 1'b0, "R4 no holdover", seen_hold, 0);
    measure(1, sp);
    check(sp == exp_spacing(3, 4), "R4 B spacing", sp, exp_spacing(3, 4));

    // R5 / R6 holdover
    en_a = 0; en_b = 0;
    cycles(150);
    check(stat_holdover == 1'b1, "R5 holdover", stat_holdover, 1);
    check(cp_mode == 2'd1, "R6 tristate", cp_mode, 1);
    c0 = pulse_cnt; cycles(200);
    check(pulse_cnt == c0, "R5 quiet", pulse_cnt - c0, 0);
    hold_mid_en = 1; cycles(3);
    check(cp_mode == 2'd2, "R6 midscale", cp_mode, 2);

    // R7 recovery through A
    half_a = 5; en_a = 1;
    cycles(34);
    check(stat_holdover == 1'b1, "R3 recovery needs 4 edges", stat_holdover, 1);
    cycles(46);
    check(stat_holdover == 1'b0, "R7 holdover left", stat_holdover, 0);
    check(cp_mode == 2'd0, "R7 cp drive", cp_mode, 0);
    cycles(60);
    check(stat_sel_b == 1'b0, "R7 A selected", stat_sel_b, 0);
    measure(1, sp);
    check(sp == exp_spacing(2, 5), "R7 A spacing", sp, exp_spacing(2, 5));

    // R8 / R9 manual modes
    en_b = 1; cycles(100);
    sel_mode = 3'd1; sel_pin = 1; cycles(10);
    check(stat_sel_b == 1'b0, "R9 manual status", stat_sel_b, 0);
    measure(1, sp);
    check(sp == exp_spacing(3, 4), "R8 pin B", sp, exp_spacing(3, 4));
    sel_pin = 0; measure(1, sp);
    check(sp == exp_spacing(2, 5), "R8 pin A", sp, exp_spacing(2, 5));
    sel_mode = 3'd3; measure(1, sp);
    check(sp == exp_spacing(3, 4), "R8 force B", sp, exp_spacing(3, 4));
    sel_mode = 3'd6; cycles(20);
    check(stat_sel_b == 1'b1, "R9 auto status B", stat_sel_b, 1);

    // R10 switch on new strobe only
    sel_mode = 3'd2; div_a_val = 10'd1; half_a = 2;
    div_b_val = 10'd6; half_b = 5; cycles(100);
    sel_mode = 3'd3; cycles(4);
    c0 = pulse_cnt; cycles(58);
    check(pulse_cnt - c0 <= 1, "R10 no old pulses", pulse_cnt - c0, 1);
    measure(0, sp);
    check(sp == exp_spacing(6, 5), "R10 B spacing", sp, exp_spacing(6, 5));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule